// File: doc/BRIEF.md
# Control Register File with Side Effects

This block holds the control and status registers of one processor core behind a single indexed port. A six-bit index picks a register. The read data follows the index combinationally. A write strobe stores the masked write data into the selected register at the next rising clock edge. Each register keeps only its architectural width. For the floating-point pointer registers, that width depends on whether the core runs in 64-bit mode.

Some registers come out of reset non-zero. Two debug indexes are aliases of two others. The floating-point status word is read back with the separate stack-top field merged into it. The interrupt-controller base register reports a bootstrap-processor bit derived from a core-identity input. Writes that change paging behaviour raise one-cycle flush requests toward the instruction and data translation buffers. These requests are asserted in the same cycle as the accepted write strobe. Unused index values raise an error and change nothing.

Index map:

| Indexes | Registers |
|---|---|
| 0–15 | Control registers CR0..CR15 |
| 16–23 | Debug registers DR0..DR7 |
| 24 | FPU control |
| 25 | FPU status |
| 26 | FPU tag |
| 27 | FPU stack top |
| 28 | FPU opcode |
| 29 | FPU instruction segment |
| 30 | FPU instruction offset |
| 31 | FPU operand segment |
| 32 | FPU operand offset |
| 33 | SIMD control/status |
| 34 | Page attribute |
| 35 | Range capability |
| 36 | Machine-check capability |
| 37 | System configuration |
| 38 | Memory top |
| 39 | Interrupt-controller base |
| 40–63 | Unused |

Top module: `ctl_reg_file`

## Requirements
- R1: After reset, the following registers read back these values: CR0 (index 0) reads 0x60000010, page attribute (34) reads 0x0007040600070406, memory top (38) reads 0x4000000, range capability (35) reads 0x508, machine-check capability (36) reads 0x104, and system configuration (37) reads 0x20601. Every other legal register reads zero.
- R2: After reset, DR6 (index 22) reads 0xFFFF0FF0, which is bits 31:16 and 11:4 set. DR7 (index 23) reads 0x400, which is bit 10 only.
- R3: The interrupt-controller base register (39) resets to 0xFEE00800, which is a base of 0xFEE00 in bits 51:12 plus the enable bit 11. On every read of this register, bit 8 returns 1 exactly when `coreId` is zero, whatever was stored there.
- R4: A read of the FPU status word (25) returns the stored 16-bit word with bits 13:11 replaced by bits 2:0 of the stack-top register (27).
- R5: Writes keep only the low bits of these registers: 3 bits for stack top (27), 8 bits for tag (26), 16 bits for status, control and opcode (25, 24, 28), and 32 bits for SIMD control/status (33). Registers not named in R5 or R6 keep all 64 bits.
- R6: When `longMode` is 0, the segment registers (29, 31) keep 16 bits and the offset registers (30, 32) keep 32 bits. When `longMode` is 1, all four keep 64 bits.
- R7: A write to CR0 always stores bit 4 as 1. If the write changes bit 31 from its stored value, the full-flush outputs for both translation buffers pulse.
- R8: Every write to CR3 pulses the non-global flush outputs for both translation buffers.
- R9: A write to CR4 pulses the full-flush outputs for both buffers when it changes any of bits 4, 5 or 7 from their stored values.
- R10: Index 20 reads and writes the register at index 22. Index 21 reads and writes the register at index 23.
- R11: Indexes 1, 5–7, 9–15 and 40–63 are illegal. For an illegal index, `idxErr` is 1 and the read data is zero. A write to an illegal index changes no register and raises no flush.
- R12: A flush output is high only in a cycle where `wrEn` is high for a legal index, and it falls once `wrEn` drops. The instruction-side and data-side outputs of each kind always match. A write is not visible on the read data until after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| idx | input | 6 | Register index for read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 64 | Write data |
| longMode | input | 1 | 1 when the core is in 64-bit mode |
| coreId | input | CORE_W (8) | Identity of the owning core |
| rdData | output | 64 | Composed read data for `idx` |
| idxErr | output | 1 | `idx` names no register |
| itbFlushAll | output | 1 | Full flush request, instruction buffer |
| dtbFlushAll | output | 1 | Full flush request, data buffer |
| itbFlushNonGlobal | output | 1 | Non-global flush request, instruction buffer |
| dtbFlushNonGlobal | output | 1 | Non-global flush request, data buffer |

## Verification
The testbench first sweeps every one of the 64 index values after reset, using two core identities. This separates the reset constants, the error decode and the bootstrap bit. It then writes four data patterns to every index, in both modes, and re-reads the whole index space after each write. All-ones exposes the width masks. Zero exposes the forced CR0 bit. The alternating patterns flip the paging bits, so the full-flush conditions are seen both firing and staying quiet. Writes through the alias indexes and to illegal indexes are caught by the full re-read, which shows whether the target register or any unrelated register changed.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int DATA_W    = 64;
  localparam int IDX_W     = 6;
  localparam int NUM_SLOTS = 40;

  localparam logic [IDX_W-1:0] SLOT_LIMIT = IDX_W'(NUM_SLOTS);
  localparam logic [IDX_W-1:0] S_CR0   = IDX_W'(0);
  localparam logic [IDX_W-1:0] S_CR3   = IDX_W'(3);
  localparam logic [IDX_W-1:0] S_CR4   = IDX_W'(4);
  localparam logic [IDX_W-1:0] S_CR8   = IDX_W'(8);
  localparam logic [IDX_W-1:0] S_DR4   = IDX_W'(20);
  localparam logic [IDX_W-1:0] S_DR5   = IDX_W'(21);
  localparam logic [IDX_W-1:0] S_DR6   = IDX_W'(22);
  localparam logic [IDX_W-1:0] S_DR7   = IDX_W'(23);
  localparam logic [IDX_W-1:0] S_FCW   = IDX_W'(24);
  localparam logic [IDX_W-1:0] S_FSW   = IDX_W'(25);
  localparam logic [IDX_W-1:0] S_FTW   = IDX_W'(26);
  localparam logic [IDX_W-1:0] S_FTOP  = IDX_W'(27);
  localparam logic [IDX_W-1:0] S_FOP   = IDX_W'(28);
  localparam logic [IDX_W-1:0] S_FISEG = IDX_W'(29);
  localparam logic [IDX_W-1:0] S_FIOFF = IDX_W'(30);
  localparam logic [IDX_W-1:0] S_FOSEG = IDX_W'(31);
  localparam logic [IDX_W-1:0] S_FOOFF = IDX_W'(32);
  localparam logic [IDX_W-1:0] S_SIMD  = IDX_W'(33);
  localparam logic [IDX_W-1:0] S_PAT   = IDX_W'(34);
  localparam logic [IDX_W-1:0] S_RCAP  = IDX_W'(35);
  localparam logic [IDX_W-1:0] S_MCAP  = IDX_W'(36);
  localparam logic [IDX_W-1:0] S_SCFG  = IDX_W'(37);
  localparam logic [IDX_W-1:0] S_MTOP  = IDX_W'(38);
  localparam logic [IDX_W-1:0] S_APIC  = IDX_W'(39);

  localparam int CR0_ET   = 4;
  localparam int CR0_PG   = 31;
  localparam int CR4_PSE  = 4;
  localparam int CR4_PAE  = 5;
  localparam int CR4_PGE  = 7;
  localparam int APIC_BSP = 8;
  localparam int TOP_LSB  = 11;
  localparam int TOP_W    = 3;

  // Write command handed from decode to storage.
  typedef struct packed {
    logic              wr;
    logic [IDX_W-1:0]  slot;
    logic [DATA_W-1:0] data;
  } wrCmd_t;

  function automatic logic [DATA_W-1:0] lowMask(input int w);
    lowMask = (DATA_W'(1) << w) - DATA_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] resetValue(input logic [IDX_W-1:0] s);
    case (s)
      S_CR0:   resetValue = DATA_W'(64'h0000_0000_6000_0010);
      S_DR6:   resetValue = DATA_W'(64'h0000_0000_FFFF_0FF0);
      S_DR7:   resetValue = DATA_W'(64'h0000_0000_0000_0400);
      S_PAT:   resetValue = DATA_W'(64'h0007_0406_0007_0406);
      S_RCAP:  resetValue = DATA_W'(64'h0508);
      S_MCAP:  resetValue = DATA_W'(64'h0104);
      S_SCFG:  resetValue = DATA_W'(64'h0002_0601);
      S_MTOP:  resetValue = DATA_W'(64'h0400_0000);
      S_APIC:  resetValue = DATA_W'(64'hFEE0_0800);
      default: resetValue = '0;
    endcase
  endfunction
endpackage

// File: rtl/crf_ctl.sv
module crf_ctl
  import crf_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              longMode,
  input  logic              curPg,
  input  logic [2:0]        curCr4Paging,
  output wrCmd_t            cmd,
  output logic [IDX_W-1:0]  rdSlot,
  output logic              legal,
  output logic              fullFlush,
  output logic              ngFlush
);
  logic [IDX_W-1:0]  slot;
  logic [DATA_W-1:0] keepMask;
  logic              accept;

  always_comb begin
    slot = idx;
    if (idx == S_DR4) slot = S_DR6;
    if (idx == S_DR5) slot = S_DR7;
  end

  always_comb begin
    legal = (idx < SLOT_LIMIT);
    if (idx == IDX_W'(1)) legal = 1'b0;
    if (idx >= IDX_W'(5) && idx <= IDX_W'(7)) legal = 1'b0;
    if (idx > S_CR8 && idx <= IDX_W'(15)) legal = 1'b0;
  end

  always_comb begin
    case (slot)
      S_FTOP:                keepMask = lowMask(TOP_W);
      S_FTW:                 keepMask = lowMask(8);
      S_FSW, S_FCW, S_FOP:   keepMask = lowMask(16);
      S_SIMD:                keepMask = lowMask(32);
      S_FISEG, S_FOSEG:      keepMask = longMode ? '1 : lowMask(16);
      S_FIOFF, S_FOOFF:      keepMask = longMode ? '1 : lowMask(32);
      default:               keepMask = '1;
    endcase
  end

  assign accept   = wrEn & legal;
  assign rdSlot   = slot;
  assign cmd.wr   = accept;
  assign cmd.slot = slot;
  assign cmd.data = (wrData & keepMask) |
                    ((slot == S_CR0) ? (DATA_W'(1) << CR0_ET) : '0);

  assign fullFlush = accept &
    (((slot == S_CR0) & (curPg ^ wrData[CR0_PG])) |
     ((slot == S_CR4) &
      (|(curCr4Paging ^ {wrData[CR4_PGE], wrData[CR4_PAE], wrData[CR4_PSE]}))));
  assign ngFlush = accept & (slot == S_CR3);
endmodule

// File: rtl/crf_dp.sv
module crf_dp
  import crf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrCmd_t            cmd,
  input  logic [IDX_W-1:0]  rdSlot,
  input  logic              rdLegal,
  input  logic              coreIsZero,
  output logic [DATA_W-1:0] rdData,
  output logic              curPg,
  output logic [2:0]        curCr4Paging
);
  logic [NUM_SLOTS-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) regs[i] <= resetValue(IDX_W'(i));
    end else if (cmd.wr) begin
      regs[cmd.slot] <= cmd.data;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdLegal) begin
      rdData = regs[rdSlot];
      if (rdSlot == S_FSW) rdData[TOP_LSB +: TOP_W] = regs[S_FTOP][TOP_W-1:0];
      if (rdSlot == S_APIC) rdData[APIC_BSP] = coreIsZero;
    end
  end

  assign curPg        = regs[S_CR0][CR0_PG];
  assign curCr4Paging = {regs[S_CR4][CR4_PGE], regs[S_CR4][CR4_PAE], regs[S_CR4][CR4_PSE]};

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.wr |=> $stable(regs));
  // R7
  et_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wr && cmd.slot == S_CR0) |=> regs[S_CR0][CR0_ET]);
  // R5
  top_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    regs[S_FTOP][DATA_W-1:TOP_W] == '0);
endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import crf_pkg::*;
#(
  parameter int CORE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              longMode,
  input  logic [CORE_W-1:0] coreId,
  output logic [DATA_W-1:0] rdData,
  output logic              idxErr,
  output logic              itbFlushAll,
  output logic              dtbFlushAll,
  output logic              itbFlushNonGlobal,
  output logic              dtbFlushNonGlobal
);
  wrCmd_t           cmd;
  logic [IDX_W-1:0] rdSlot;
  logic             legal;
  logic             fullFlush;
  logic             ngFlush;
  logic             curPg;
  logic [2:0]       curCr4Paging;

  crf_ctl u_ctl (
    .idx          (idx),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .longMode     (longMode),
    .curPg        (curPg),
    .curCr4Paging (curCr4Paging),
    .cmd          (cmd),
    .rdSlot       (rdSlot),
    .legal        (legal),
    .fullFlush    (fullFlush),
    .ngFlush      (ngFlush)
  );

  crf_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .rdSlot       (rdSlot),
    .rdLegal      (legal),
    .coreIsZero   (coreId == '0),
    .rdData       (rdData),
    .curPg        (curPg),
    .curCr4Paging (curCr4Paging)
  );

  assign idxErr            = !legal;
  assign itbFlushAll       = fullFlush;
  assign dtbFlushAll       = fullFlush;
  assign itbFlushNonGlobal = ngFlush;
  assign dtbFlushNonGlobal = ngFlush;

  // R12
  flush_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (itbFlushAll || itbFlushNonGlobal) |-> (wrEn && !idxErr));
  // R11
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxErr |-> (!dtbFlushAll && !dtbFlushNonGlobal));
  // R8
  cr3_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == S_CR3) |-> dtbFlushNonGlobal);
endmodule

// File: tb/ctl_reg_file_bench.sv
`timescale 1ns/1ps
module ctl_reg_file_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  idx = '0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        longMode = 1'b0;
  logic [7:0]  coreId = '0;
  logic [63:0] rdData;
  logic        idxErr, itbFlushAll, dtbFlushAll, itbFlushNonGlobal, dtbFlushNonGlobal;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic [63:0] m [0:39];

  always #2 clk = ~clk;

  ctl_reg_file u_ctl_reg_file (
    .clk(clk), .rstN(rstN), .idx(idx), .wrEn(wrEn), .wrData(wrData),
    .longMode(longMode), .coreId(coreId), .rdData(rdData), .idxErr(idxErr),
    .itbFlushAll(itbFlushAll), .dtbFlushAll(dtbFlushAll),
    .itbFlushNonGlobal(itbFlushNonGlobal), .dtbFlushNonGlobal(dtbFlushNonGlobal)
  );

  function automatic bit isIllegal(int i);
    return i >= 40 || i == 1 || (i >= 5 && i <= 7) || (i >= 9 && i <= 15);
  endfunction

  function automatic int aliasOf(int i);
    if (i == 20) return 22;
    if (i == 21) return 23;
    return i;
  endfunction

  function automatic logic [63:0] keepOf(int s, bit lm);
    case (s)
      27: return 64'h7;
      26: return 64'hFF;
      24, 25, 28: return 64'hFFFF;
      33: return 64'hFFFF_FFFF;
      29, 31: return lm ? '1 : 64'hFFFF;
      30, 32: return lm ? '1 : 64'hFFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [63:0] modelRead(int i, int c);
    logic [63:0] v;
    int s;
    if (isIllegal(i)) return '0;
    s = aliasOf(i);
    v = m[s];
    if (s == 25) v[13:11] = m[27][2:0];
    if (s == 39) v[8] = (c == 0);
    return v;
  endfunction

  function automatic string resetTag(int i);
    if (isIllegal(i)) return "R11";
    if (i >= 20 && i <= 23) return "R2";
    if (i == 39) return "R3";
    return "R1";
  endfunction

  function automatic string tagOf(int i);
    if (isIllegal(i)) return "R11";
    if (i == 20 || i == 21) return "R10";
    if (i == 25) return "R4";
    if (i >= 29 && i <= 32) return "R6";
    if (i == 24 || i == 26 || i == 27 || i == 28 || i == 33) return "R5";
    if (i == 0) return "R7";
    if (i == 39) return "R3";
    return "R1";
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%016h expected 0x%016h", req, what, act, exp);
    end
  endtask

  task automatic readOne(int i, int c, string req);
    logic [63:0] e;
    @(negedge clk);
    idx = 6'(i); wrEn = 1'b0; coreId = 8'(c);
    #1;
    e = modelRead(i, c);
    chk(rdData === e, req, $sformatf("read idx %0d", i), rdData, e);
    chk(idxErr === isIllegal(i), "R11", $sformatf("idxErr idx %0d", i),
        64'(idxErr), 64'(isIllegal(i)));
  endtask

  task automatic readAll(int c, bit afterReset);
    for (int i = 0; i < 64; i++) readOne(i, c, afterReset ? resetTag(i) : tagOf(i));
  endtask

  task automatic doWrite(int i, logic [63:0] d, bit lm);
    int s;
    bit eAll, eNg;
    string ftag;
    logic [63:0] oldRd;
    s = aliasOf(i);
    eAll = !isIllegal(i) &&
           ((s == 0 && m[0][31] != d[31]) || (s == 4 && ((m[4] ^ d) & 64'hB0) != 0));
    eNg = !isIllegal(i) && s == 3;
    ftag = (s == 0) ? "R7" : (s == 3) ? "R8" : (s == 4) ? "R9" :
           isIllegal(i) ? "R11" : "R12";
    oldRd = modelRead(i, 0);
    @(negedge clk);
    idx = 6'(i); wrData = d; wrEn = 1'b1; longMode = lm; coreId = '0;
    #1;
    chk(itbFlushAll === eAll, ftag, "itbFlushAll", 64'(itbFlushAll), 64'(eAll));
    chk(dtbFlushAll === eAll, ftag, "dtbFlushAll", 64'(dtbFlushAll), 64'(eAll));
    chk(itbFlushNonGlobal === eNg, ftag, "itbFlushNonGlobal", 64'(itbFlushNonGlobal), 64'(eNg));
    chk(dtbFlushNonGlobal === eNg, ftag, "dtbFlushNonGlobal", 64'(dtbFlushNonGlobal), 64'(eNg));
    chk(rdData === oldRd, "R12", "read before edge", rdData, oldRd);
    @(posedge clk);
    if (!isIllegal(i)) m[s] = (d & keepOf(s, lm)) | ((s == 0) ? 64'h10 : 64'h0);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    chk({itbFlushAll, dtbFlushAll, itbFlushNonGlobal, dtbFlushNonGlobal} === 4'b0, "R12",
        "flush after strobe drop",
        64'({itbFlushAll, dtbFlushAll, itbFlushNonGlobal, dtbFlushNonGlobal}), 64'h0);
  endtask

  initial begin
    logic [63:0] pats [4];
    pats[0] = '1;
    pats[1] = '0;
    pats[2] = 64'hA5A5_A5A5_A5A5_A5A5;
    pats[3] = 64'h5A5A_5A5A_5A5A_5A5A;
    for (int i = 0; i < 40; i++) m[i] = '0;
    m[0]  = 64'h6000_0010;
    m[22] = 64'hFFFF_0FF0;
    m[23] = 64'h400;
    m[34] = 64'h0007_0406_0007_0406;
    m[35] = 64'h508;
    m[36] = 64'h104;
    m[37] = 64'h2_0601;
    m[38] = 64'h400_0000;
    m[39] = 64'hFEE0_0800;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    readAll(0, 1'b1);
    readAll(5, 1'b1);
    for (int lm = 0; lm < 2; lm++) begin
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < 64; i++) begin
          doWrite(i, pats[p], lm[0]);
          readAll((i % 2 == 0) ? 0 : 3, 1'b0);
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule